// File: doc/BRIEF.md
# CSMA/CD Transmit Collision Controller

This block runs one half-duplex Ethernet frame onto the wire, one bit per bit-time enable, and handles every collision that hits it. Each attempt sends a preamble and start delimiter, then the frame bits pulled one at a time from an external frame buffer. If a collision is seen, the data is cut and a jam pattern goes out. The collision is then classed as normal or late. The block either asks a separate backoff timer for permission to try again, or it gives the frame up and tells the buffer to discard it.

A new frame is started by a one-cycle `frameStart` pulse with its length in bits. The buffer supplies the current bit on `dataBit`, advances on `dataRd` and rewinds to the frame's first bit on `rewind`. The backoff timer sees a level request with the number of retries so far, and answers with a one-cycle grant. `done` pulses once per frame, and the four status flags are valid from that pulse until the next frame starts.

Top module: `csmaTxSequencer`

## Requirements
- R1: An attempt sends PRE_BITS delimiter bits in the order 1,0,1,0,…,1,1 (alternating from 1, the last bit 1), with `txEn` high. A collision sampled during these bits does not shorten them: all of them go out, and the jam follows straight after the last one.
- R2: Frame bits follow the delimiter in buffer order, and `dataRd` is high on each enable that completes a frame bit. A collision sampled on a frame bit makes that bit the last one sent, and the jam starts on the next bit time.
- R3: The jam is JAM_BITS bits of 0 with `txEn` high. `txEn` is low while the block is idle or waiting for backoff.
- R4: After a jam for a normal collision, with retries enabled and attempts left, `backoffReq` is held high and `backoffCnt` gives the number of retries including this one. A `backoffGrant` gives a one-cycle `rewind` pulse and a fresh attempt that starts from the delimiter.
- R5: A frame that gets through sets `stOne` if exactly one retry was used and `stMore` if more than one was used. Both are clear if there was none.
- R6: If the attempt numbered MAX_ATTEMPTS (first try included) also ends in a normal collision, only `stRtry` is set and `flush` pulses.
- R7: With `retryDis` high, the first normal collision ends the frame after its jam. Only `stRtry` is set, `flush` pulses, and no backoff is requested.
- R8: A collision sampled on frame bit index SLOT_BITS or later (index 0 is the first bit after the delimiter) is late. After the jam, `stLcol` is set, `flush` pulses and no retry follows. `stOne` and `stMore` still report the retries made before it. A late collision takes priority over `retryDis` and exhaustion.
- R9: `done` pulses for exactly one cycle, in the cycle after the edge that completes the frame's final bit. The status flags are valid from then until the next `frameStart`, which clears them. `flush` pulses only together with `done` on a failure.
- R10: `colIn` and the bit sequence act only on cycles with `bitEn` high. A collision input present on other cycles has no effect.
- R11: After reset, `txEn`, `done`, `flush`, `rewind`, `backoffReq` and all status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One-cycle strobe per bit time |
| frameStart | input | 1 | Starts a frame when idle |
| frameLen | input | LEN_W | Frame length in bits, at least 1, taken at start |
| dataBit | input | 1 | Current frame bit from the buffer |
| dataRd | output | 1 | Advance the buffer to the next bit |
| rewind | output | 1 | Return the buffer to the frame's first bit |
| txEn | output | 1 | Transmit enable toward the line coder |
| txBit | output | 1 | Serial transmit bit |
| colIn | input | 1 | Collision detect |
| retryDis | input | 1 | Give up on the first collision |
| backoffReq | output | 1 | Request to the backoff timer |
| backoffCnt | output | ATT_W | Retries so far, used by the backoff timer |
| backoffGrant | input | 1 | Backoff elapsed, start the next attempt |
| done | output | 1 | End-of-frame pulse |
| flush | output | 1 | Discard the frame in the buffer |
| stOne | output | 1 | Exactly one retry used |
| stMore | output | 1 | More than one retry used |
| stRtry | output | 1 | Frame abandoned after normal collisions |
| stLcol | output | 1 | Late collision |

## Verification
The bench builds the block with an 8-bit delimiter, a 16-bit slot, a 4-bit jam and the full 16 attempts. With these sizes the slot edge can be hit from both sides (frame bits 15 and 16) within a short frame, and a run through every retry up to exhaustion stays short. The bit enable fires every second clock, and collision is held high on the cycles in between, so any sampling outside the enable would change the wire sequence or the status.

// File: rtl/csmaTxPkg.sv
package csmaTxPkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_DATA,
    PH_JAM,
    PH_WAIT
  } txPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic lenLoad;
    logic cntClr;
    logic cntInc;
    logic pendClr;
  } dpCmd_t;

  // conditions reported by datapath to control
  typedef struct packed {
    logic preLast;
    logic dataLast;
    logic jamLast;
    logic colPend;
    logic pastSlot;
  } dpFlag_t;

endpackage

// File: rtl/csmaTxDatapath.sv
module csmaTxDatapath
  import csmaTxPkg::*;
#(
  parameter int PRE_BITS  = 64,
  parameter int SLOT_BITS = 512,
  parameter int JAM_BITS  = 32,
  parameter int LEN_W     = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  txPhase_t         phase,
  input  dpCmd_t           cmd,
  input  logic             bitEn,
  input  logic             colIn,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             dataBit,
  output dpFlag_t          flags,
  output logic             txEn,
  output logic             txBit,
  output logic             dataRd
);

  localparam int PHASE_W = $clog2(PRE_BITS + JAM_BITS + 1);
  localparam int CW      = (LEN_W > PHASE_W) ? LEN_W : PHASE_W;

  logic [CW-1:0]    bitCnt;
  logic [LEN_W-1:0] lenQ;
  logic             colPend;
  logic             preBit;

  // shared bit counter, restarted at every phase boundary
  always_ff @(posedge clk) begin
    if (!rstN)           bitCnt <= '0;
    else if (cmd.cntClr) bitCnt <= '0;
    else if (cmd.cntInc) bitCnt <= bitCnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            lenQ <= '0;
    else if (cmd.lenLoad) lenQ <= frameLen;
  end

  // a collision during the delimiter is remembered until it ends
  always_ff @(posedge clk) begin
    if (!rstN)                                     colPend <= 1'b0;
    else if (cmd.pendClr)                          colPend <= 1'b0;
    else if (phase == PH_PRE && bitEn && colIn)    colPend <= 1'b1;
  end

  assign preBit = (bitCnt == CW'(PRE_BITS - 1)) ? 1'b1 : ~bitCnt[0];

  always_comb begin
    flags.preLast  = (phase == PH_PRE)  && (bitCnt == CW'(PRE_BITS - 1));
    flags.dataLast = (phase == PH_DATA) && (bitCnt == (CW'(lenQ) - CW'(1)));
    flags.jamLast  = (phase == PH_JAM)  && (bitCnt == CW'(JAM_BITS - 1));
    flags.colPend  = colPend;
    flags.pastSlot = (phase == PH_DATA) && (32'(bitCnt) >= SLOT_BITS);
  end

  always_comb begin
    txEn  = 1'b0;
    txBit = 1'b0;
    unique case (phase)
      PH_PRE:  begin txEn = 1'b1; txBit = preBit;  end
      PH_DATA: begin txEn = 1'b1; txBit = dataBit; end
      PH_JAM:  begin txEn = 1'b1; txBit = 1'b0;    end
      default: begin txEn = 1'b0; txBit = 1'b0;    end
    endcase
  end

  assign dataRd = (phase == PH_DATA) && bitEn;

endmodule

// File: rtl/csmaTxControl.sv
module csmaTxControl
  import csmaTxPkg::*;
#(
  parameter int MAX_ATTEMPTS = 16,
  parameter int ATT_W        = $clog2(MAX_ATTEMPTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             frameStart,
  input  logic             colIn,
  input  logic             retryDis,
  input  logic             backoffGrant,
  input  dpFlag_t          flags,
  output txPhase_t         phase,
  output dpCmd_t           cmd,
  output logic             backoffReq,
  output logic [ATT_W-1:0] backoffCnt,
  output logic             done,
  output logic             flush,
  output logic             rewind,
  output logic             stOne,
  output logic             stMore,
  output logic             stRtry,
  output logic             stLcol
);

  txPhase_t         phaseQ, phaseD;
  logic [ATT_W-1:0] retryCnt;
  logic             lateQ;
  logic             startFrame, retryInc, lateLd, lateVal, rewindD;
  logic             finish, finOne, finMore, finRtry, finLcol, finFlush;
  logic             doneQ, flushQ, rewindQ;
  logic             oneQ, moreQ, rtryQ, lcolQ;

  always_comb begin
    phaseD     = phaseQ;
    cmd        = '0;
    startFrame = 1'b0;
    retryInc   = 1'b0;
    lateLd     = 1'b0;
    lateVal    = 1'b0;
    rewindD    = 1'b0;
    finish     = 1'b0;
    finOne     = 1'b0;
    finMore    = 1'b0;
    finRtry    = 1'b0;
    finLcol    = 1'b0;
    finFlush   = 1'b0;
    unique case (phaseQ)
      PH_IDLE: begin
        if (frameStart) begin
          startFrame  = 1'b1;
          cmd.lenLoad = 1'b1;
          cmd.cntClr  = 1'b1;
          cmd.pendClr = 1'b1;
          phaseD      = PH_PRE;
        end
      end
      PH_PRE: begin
        if (bitEn) begin
          if (flags.preLast) begin
            cmd.cntClr = 1'b1;
            lateLd     = 1'b1;
            lateVal    = 1'b0;
            phaseD     = (flags.colPend || colIn) ? PH_JAM : PH_DATA;
          end else begin
            cmd.cntInc = 1'b1;
          end
        end
      end
      PH_DATA: begin
        if (bitEn) begin
          if (colIn) begin
            cmd.cntClr = 1'b1;
            lateLd     = 1'b1;
            lateVal    = flags.pastSlot;
            phaseD     = PH_JAM;
          end else if (flags.dataLast) begin
            finish  = 1'b1;
            finOne  = (retryCnt == ATT_W'(1));
            finMore = (retryCnt > ATT_W'(1));
            phaseD  = PH_IDLE;
          end else begin
            cmd.cntInc = 1'b1;
          end
        end
      end
      PH_JAM: begin
        if (bitEn) begin
          if (flags.jamLast) begin
            cmd.cntClr = 1'b1;
            if (lateQ) begin
              finish   = 1'b1;
              finLcol  = 1'b1;
              finOne   = (retryCnt == ATT_W'(1));
              finMore  = (retryCnt > ATT_W'(1));
              finFlush = 1'b1;
              phaseD   = PH_IDLE;
            end else if (retryDis || retryCnt == ATT_W'(MAX_ATTEMPTS - 1)) begin
              finish   = 1'b1;
              finRtry  = 1'b1;
              finFlush = 1'b1;
              phaseD   = PH_IDLE;
            end else begin
              retryInc = 1'b1;
              phaseD   = PH_WAIT;
            end
          end else begin
            cmd.cntInc = 1'b1;
          end
        end
      end
      PH_WAIT: begin
        if (backoffGrant) begin
          rewindD     = 1'b1;
          cmd.cntClr  = 1'b1;
          cmd.pendClr = 1'b1;
          phaseD      = PH_PRE;
        end
      end
      default: phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ   <= PH_IDLE;
      retryCnt <= '0;
      lateQ    <= 1'b0;
      doneQ    <= 1'b0;
      flushQ   <= 1'b0;
      rewindQ  <= 1'b0;
    end else begin
      phaseQ  <= phaseD;
      doneQ   <= finish;
      flushQ  <= finFlush;
      rewindQ <= rewindD;
      if (startFrame)    retryCnt <= '0;
      else if (retryInc) retryCnt <= retryCnt + ATT_W'(1);
      if (lateLd)        lateQ <= lateVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || startFrame) begin
      oneQ  <= 1'b0;
      moreQ <= 1'b0;
      rtryQ <= 1'b0;
      lcolQ <= 1'b0;
    end else if (finish) begin
      oneQ  <= finOne;
      moreQ <= finMore;
      rtryQ <= finRtry;
      lcolQ <= finLcol;
    end
  end

  assign phase      = phaseQ;
  assign backoffReq = (phaseQ == PH_WAIT);
  assign backoffCnt = retryCnt;
  assign done       = doneQ;
  assign flush      = flushQ;
  assign rewind     = rewindQ;
  assign stOne      = oneQ;
  assign stMore     = moreQ;
  assign stRtry     = rtryQ;
  assign stLcol     = lcolQ;

endmodule

// File: rtl/csmaTxSequencer.sv
module csmaTxSequencer
  import csmaTxPkg::*;
#(
  parameter int PRE_BITS     = 64,
  parameter int SLOT_BITS    = 512,
  parameter int JAM_BITS     = 32,
  parameter int MAX_ATTEMPTS = 16,
  parameter int LEN_W        = 14,
  parameter int ATT_W        = $clog2(MAX_ATTEMPTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             frameStart,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             dataBit,
  output logic             dataRd,
  output logic             rewind,
  output logic             txEn,
  output logic             txBit,
  input  logic             colIn,
  input  logic             retryDis,
  output logic             backoffReq,
  output logic [ATT_W-1:0] backoffCnt,
  input  logic             backoffGrant,
  output logic             done,
  output logic             flush,
  output logic             stOne,
  output logic             stMore,
  output logic             stRtry,
  output logic             stLcol
);

  txPhase_t phase;
  dpCmd_t   cmd;
  dpFlag_t  flags;

  csmaTxControl #(
    .MAX_ATTEMPTS(MAX_ATTEMPTS),
    .ATT_W       (ATT_W)
  ) uCtl (
    .clk         (clk),
    .rstN        (rstN),
    .bitEn       (bitEn),
    .frameStart  (frameStart),
    .colIn       (colIn),
    .retryDis    (retryDis),
    .backoffGrant(backoffGrant),
    .flags       (flags),
    .phase       (phase),
    .cmd         (cmd),
    .backoffReq  (backoffReq),
    .backoffCnt  (backoffCnt),
    .done        (done),
    .flush       (flush),
    .rewind      (rewind),
    .stOne       (stOne),
    .stMore      (stMore),
    .stRtry      (stRtry),
    .stLcol      (stLcol)
  );

  csmaTxDatapath #(
    .PRE_BITS (PRE_BITS),
    .SLOT_BITS(SLOT_BITS),
    .JAM_BITS (JAM_BITS),
    .LEN_W    (LEN_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .phase   (phase),
    .cmd     (cmd),
    .bitEn   (bitEn),
    .colIn   (colIn),
    .frameLen(frameLen),
    .dataBit (dataBit),
    .flags   (flags),
    .txEn    (txEn),
    .txBit   (txBit),
    .dataRd  (dataRd)
  );

endmodule

// File: rtl/csmaTxChecker.sv
module csmaTxChecker (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic txEn,
  input logic dataRd,
  input logic done,
  input logic flush,
  input logic rewind,
  input logic backoffReq,
  input logic stOne,
  input logic stMore,
  input logic stRtry,
  input logic stLcol
);

  assert_read_while_sending_R2: assert property (@(posedge clk) disable iff (!rstN)
    dataRd |-> txEn);

  assert_quiet_in_backoff_R4: assert property (@(posedge clk) disable iff (!rstN)
    backoffReq |-> !txEn);

  assert_rewind_starts_attempt_R4: assert property (@(posedge clk) disable iff (!rstN)
    rewind |-> (txEn && !backoffReq));

  assert_give_up_alone_R6: assert property (@(posedge clk) disable iff (!rstN)
    stRtry |-> (!stOne && !stMore && !stLcol));

  assert_late_not_exhausted_R8: assert property (@(posedge clk) disable iff (!rstN)
    stLcol |-> !stRtry);

  assert_flush_on_failure_R9: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (done && (stRtry || stLcol)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_hold_between_enables_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && !bitEn) |=> txEn);

endmodule

bind csmaTxSequencer csmaTxChecker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .bitEn     (bitEn),
  .txEn      (txEn),
  .dataRd    (dataRd),
  .done      (done),
  .flush     (flush),
  .rewind    (rewind),
  .backoffReq(backoffReq),
  .stOne     (stOne),
  .stMore    (stMore),
  .stRtry    (stRtry),
  .stLcol    (stLcol)
);

// File: tb/csmaTxSequencer_test.sv
module csmaTxSequencer_test;

  localparam int PRE  = 8;
  localparam int SLOT = 16;
  localparam int JAM  = 4;
  localparam int MAXA = 16;
  localparam int LW   = 8;
  localparam int AW   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic frameStart = 1'b0;
  logic [LW-1:0] frameLen = '0;
  logic colIn = 1'b0;
  logic retryDis = 1'b0;
  logic backoffGrant = 1'b0;
  logic dataBit;
  logic dataRd, rewind, txEn, txBit, backoffReq, done, flush;
  logic stOne, stMore, stRtry, stLcol;
  logic [AW-1:0] backoffCnt;

  int passCnt = 0;
  int failCnt = 0;
  int rdIdx = 0;
  int colPlan[MAXA];

  always #5 clk = ~clk;

  csmaTxSequencer #(
    .PRE_BITS(PRE), .SLOT_BITS(SLOT), .JAM_BITS(JAM),
    .MAX_ATTEMPTS(MAXA), .LEN_W(LW), .ATT_W(AW)
  ) uut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameStart(frameStart),
    .frameLen(frameLen), .dataBit(dataBit), .dataRd(dataRd), .rewind(rewind),
    .txEn(txEn), .txBit(txBit), .colIn(colIn), .retryDis(retryDis),
    .backoffReq(backoffReq), .backoffCnt(backoffCnt), .backoffGrant(backoffGrant),
    .done(done), .flush(flush), .stOne(stOne), .stMore(stMore),
    .stRtry(stRtry), .stLcol(stLcol)
  );

  function automatic logic payload(input int d);
    return d[0] ^ d[2];
  endfunction

  // frame buffer model
  assign dataBit = payload(rdIdx);
  always @(posedge clk) begin
    if (rewind || frameStart) rdIdx <= 0;
    else if (dataRd)          rdIdx <= rdIdx + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  endtask

  task automatic clearPlan();
    for (int i = 0; i < MAXA; i++) colPlan[i] = -1;
  endtask

  // one bit time: enable cycle, then a gap cycle with collision noise
  task automatic stepBit(input logic c, output logic en, output logic b);
    @(negedge clk);
    bitEn = 1'b1; colIn = c;
    en = txEn; b = txBit;
    @(negedge clk);
    bitEn = 1'b0; colIn = 1'b1;
  endtask

  task automatic runFrame(input int len, input bit dis, input int expOne,
                          input int expMore, input int expRtry, input int expLcol);
    int att = 0;
    int waveErr = 0;
    bit finished = 0;
    logic en, b;
    retryDis = dis;
    frameLen = LW'(len);
    @(negedge clk); frameStart = 1'b1;
    @(negedge clk); frameStart = 1'b0;
    // R9: a new frame clears the previous status
    check({stOne, stMore, stRtry, stLcol} == 4'b0, "R9", "status cleared at start",
          int'({stOne, stMore, stRtry, stLcol}), 0);
    while (!finished) begin
      int w = 0;
      bit colSeen = 0;
      bit late = 0;
      for (int i = 0; i < PRE; i++) begin
        logic c = (colPlan[att] == w);
        logic e = (i == PRE - 1) ? 1'b1 : ((i % 2) == 0);
        stepBit(c, en, b);
        if (!en || b !== e) waveErr++;           // R1
        if (c) colSeen = 1;
        w++;
      end
      if (!colSeen) begin
        for (int d = 0; d < len; d++) begin
          logic c = (colPlan[att] == w);
          stepBit(c, en, b);
          if (!en || b !== payload(d)) waveErr++; // R2
          w++;
          if (c) begin
            colSeen = 1;
            late = (d >= SLOT);
            break;
          end
        end
      end
      if (!colSeen) begin
        check(done && !flush, "R9", "done without flush on success",
              int'({done, flush}), 2);
        finished = 1;
      end else begin
        for (int j = 0; j < JAM; j++) begin
          stepBit(1'b0, en, b);
          if (!en || b !== 1'b0) waveErr++;       // R3
        end
        if (late || dis || att == MAXA - 1) begin
          check(done && flush && !backoffReq, late ? "R8" : (dis ? "R7" : "R6"),
                "done+flush without backoff", int'({done, flush, backoffReq}), 6);
          finished = 1;
        end else begin
          check(backoffReq && !txEn && !done && backoffCnt == AW'(att + 1), "R4",
                "backoff request count", int'(backoffCnt), att + 1);
          backoffGrant = 1'b1;
          @(negedge clk);
          backoffGrant = 1'b0;
          check(rewind && txEn && !backoffReq, "R4", "rewind into new attempt",
                int'({rewind, txEn, backoffReq}), 6);
          att++;
        end
      end
    end
    check(waveErr == 0, "R1", "wire bit mismatches (R2 R3)", waveErr, 0);
    check(stOne == expOne[0] && stMore == expMore[0], "R5", "retry count flags",
          int'({stOne, stMore}), expOne * 2 + expMore);
    check(stRtry == expRtry[0] && stLcol == expLcol[0], "R6", "abandon flags (R7 R8)",
          int'({stRtry, stLcol}), expRtry * 2 + expLcol);
    // one gap later: done gone, status held, line quiet
    @(negedge clk);
    check(!done && !txEn && stRtry == expRtry[0] && stLcol == expLcol[0]
          && stOne == expOne[0], "R9", "status held after done pulse",
          int'({done, txEn}), 0);
    retryDis = 1'b0;
  endtask

  task automatic testReset();
    check({txEn, done, flush, rewind, backoffReq} == 5'b0, "R11", "outputs after reset",
          int'({txEn, done, flush, rewind, backoffReq}), 0);
    check({stOne, stMore, stRtry, stLcol} == 4'b0, "R11", "status after reset",
          int'({stOne, stMore, stRtry, stLcol}), 0);
  endtask

  task automatic testClean();
    // collision noise only between enables must be ignored (R10)
    clearPlan();
    runFrame(20, 1'b0, 0, 0, 0, 0);
    check(1'b1, "R10", "clean frame under off-enable noise", 0, 0);
  endtask

  task automatic testPreambleHit();
    clearPlan();
    colPlan[0] = 2;
    runFrame(12, 1'b0, 1, 0, 0, 0);     // R1, R5 single retry
  endtask

  task automatic testTwoRetries();
    clearPlan();
    colPlan[0] = PRE;
    colPlan[1] = PRE + 5;
    runFrame(12, 1'b0, 0, 1, 0, 0);     // R2, R5 several retries
  endtask

  task automatic testSlotEdge();
    clearPlan();
    colPlan[0] = PRE + SLOT - 1;        // normal, last bit inside slot
    colPlan[1] = PRE + SLOT;            // first late bit
    runFrame(30, 1'b0, 1, 0, 0, 1);     // R8
  endtask

  task automatic testExhaust();
    clearPlan();
    for (int i = 0; i < MAXA; i++) colPlan[i] = PRE + 2;
    runFrame(10, 1'b0, 0, 0, 1, 0);     // R6
  endtask

  task automatic testDisabled();
    clearPlan();
    colPlan[0] = PRE + 3;
    runFrame(10, 1'b1, 0, 0, 1, 0);     // R7
  endtask

  task automatic testLateBeatsDisable();
    clearPlan();
    colPlan[0] = PRE + SLOT + 2;
    runFrame(24, 1'b1, 0, 0, 0, 1);     // R8 priority
  endtask

  initial begin
    #(200000 * 10);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    clearPlan();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    colIn = 1'b1;
    testClean();
    testPreambleHit();
    testTwoRetries();
    testSlotEdge();
    testExhaust();
    testDisabled();
    testLateBeatsDisable();
    testClean();
    finishRun();
  end

endmodule